// File: doc/BRIEF.md
# Slot-Based PCI Interrupt Router

This block gathers the four interrupt pins (A to D) of every PCI device sitting in slots 5 through 12 of a board and folds them onto a 32-entry bridge-internal interrupt space. The folding follows a fixed, slot-dependent swizzle. The shared south-bridge slot keeps its pins on lines 0 to 3. The two single-function slots each collapse onto one line. The four expansion slots rotate their pins across a common band of lines, so several pins can land on the same line. Pins that share a line are ORed together. In the global interrupt numbering, internal line k appears as number 32 + k. That offset is only a convention for software, and no port carries it.

Each internal line has two configuration bits. A mode bit picks pulse or level behaviour. For a line in level mode, a polarity bit picks whether an asserted line drives the CPU request high or forces it low. All lines are merged into one registered CPU interrupt output. The unregistered 32-bit line vector is also brought out, so that a downstream status or enable stage can sample it.

Pin inputs are assumed to be synchronous to `clk_i`. Configuration words may change at any clock. Each change takes effect at the next clock edge.

Top module: `pirq_router`

## Requirements
- R1: Pin n (0..3) of slot 5 drives internal line n. Pin bit position is (slot - 5) * 4 + pin.
- R2: Every pin of slot 6 drives internal line 4, and every pin of slot 7 drives internal line 5.
- R3: Pin n of slot s, for s in 8..12, drives internal line (s - 8 + n) + 6. A line fed by several pins is the OR of those pins.
- R4: Internal lines 14 to 31 have no source and always read 0 on `line_vec_o`.
- R5: `line_vec_o` follows the pins in the same cycle, with no register on the path.
- R6: When bit k of `edge_cfg_i` is 1, a 0-to-1 change of line k seen between two consecutive clock edges sets `cpu_irq_o` for exactly one cycle, starting at the second of those edges. Holding the line high does not extend the pulse.
- R7: When bit k of `edge_cfg_i` is 0 and bit k of `pol_cfg_i` is 1, `cpu_irq_o` is 1 in every cycle that follows a clock edge at which line k is 1.
- R8: When bit k of `edge_cfg_i` is 0 and bit k of `pol_cfg_i` is 0, an asserted line k forces `cpu_irq_o` to 0 after the next clock edge. This overrides every pulse and every active-high level request.
- R9: A falling line in pulse mode produces no pulse. A falling line in active-high level mode drops `cpu_irq_o` after the next clock edge.
- R10: A clock edge with `rst_ni` low clears `cpu_irq_o` and the stored previous line values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| slot_pins_i | input | 32 | Interrupt pins, bit (slot-5)*4+pin, active high |
| edge_cfg_i | input | 32 | Per-line mode: 1 = pulse, 0 = level |
| pol_cfg_i | input | 32 | Per-line level sense: 1 = drive high, 0 = force low |
| line_vec_o | output | 32 | Merged internal interrupt lines |
| cpu_irq_o | output | 1 | Registered interrupt request toward the CPU |

## Verification
The bench walks the swizzle across every slot class. It includes the rotated expansion band, where two different slots must land on the same line. A wrong offset or a missing OR would show up there as the wrong bit or as a dropped bit in `line_vec_o`. A pulse-mode line is held high for several cycles and then dropped. An edge detector whose previous-value register is missing or stale would then stretch the pulse, or would fire on the falling transition. The override rule is exercised with a force-low line asserted alongside both an active-high level request and a fresh pulse. A design that ORs instead of masking would leave `cpu_irq_o` high. Reset is asserted while a level request is active, so that a missing clear of the output register shows up.

// File: rtl/pirq_pkg.sv
// pirq_pkg
// Shared constants and the slot swizzle for the PCI interrupt router.
// Assumes slots are numbered consecutively from FIRST_SLOT and that every
// slot carries PINS_PER_SLOT pins at bit (slot-FIRST_SLOT)*PINS_PER_SLOT+pin.
package pirq_pkg;

    localparam int FIRST_SLOT    = 5;
    localparam int LAST_SLOT     = 12;
    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_LINES     = 32;
    localparam int LINE_BASE     = 32;   // global number of internal line 0

    // Board-specific slot classes
    localparam int SHARED_SLOT   = 5;    // pins keep their own line
    localparam int SOLO_A_SLOT   = 6;
    localparam int SOLO_A_LINE   = 4;
    localparam int SOLO_B_SLOT   = 7;
    localparam int SOLO_B_LINE   = 5;
    localparam int EXP_FIRST     = 8;    // rotating expansion band
    localparam int EXP_LAST      = 12;
    localparam int EXP_LINE0     = 6;

    localparam int NUM_SLOTS  = LAST_SLOT - FIRST_SLOT + 1;
    localparam int PIN_W      = NUM_SLOTS * PINS_PER_SLOT;
    localparam int USED_LINES = EXP_LINE0 + (EXP_LAST - EXP_FIRST) + PINS_PER_SLOT;
    localparam int MAX_PINS   = 256;

    // Internal line driven by one pin of one slot, or -1 when untranslated.
    function automatic int route_line(input int slot, input int pin);
        if (slot == SHARED_SLOT)
            return pin % 4;
        else if (slot == SOLO_A_SLOT)
            return SOLO_A_LINE;
        else if (slot == SOLO_B_SLOT)
            return SOLO_B_LINE;
        else if (slot >= EXP_FIRST && slot <= EXP_LAST)
            return (slot - EXP_FIRST + pin) + EXP_LINE0;
        else
            return -1;
    endfunction

    // Set of pin bits that feed a given internal line.
    function automatic logic [MAX_PINS-1:0] pin_mask(input int line, input int first_slot,
                                                     input int num_slots, input int pins);
        logic [MAX_PINS-1:0] m;
        m = '0;
        for (int s = 0; s < num_slots; s++)
            for (int p = 0; p < pins; p++)
                if (route_line(first_slot + s, p) == line)
                    m[s*pins + p] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pirq_swizzle.sv
// pirq_swizzle
// Folds the flat slot-pin vector onto the internal line space. Each line is
// the OR of all pins the package swizzle routes to it. Purely combinational;
// assumes pins are already synchronous to the consuming clock.
module pirq_swizzle #(
    parameter int FIRST_SLOT    = pirq_pkg::FIRST_SLOT,
    parameter int NUM_SLOTS     = pirq_pkg::NUM_SLOTS,
    parameter int PINS_PER_SLOT = pirq_pkg::PINS_PER_SLOT,
    parameter int NUM_LINES     = pirq_pkg::NUM_LINES,
    localparam int PIN_W        = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic [PIN_W-1:0]     pins_i,
    output logic [NUM_LINES-1:0] lines_o
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam logic [pirq_pkg::MAX_PINS-1:0] FULL_MASK =
            pirq_pkg::pin_mask(l, FIRST_SLOT, NUM_SLOTS, PINS_PER_SLOT);
        localparam logic [PIN_W-1:0] MASK = FULL_MASK[PIN_W-1:0];
        // OR of every pin routed to this line
        assign lines_o[l] = |(pins_i & MASK);
    end

endmodule

// File: rtl/pirq_line_cond.sv
// pirq_line_cond
// Conditions one internal line: in pulse mode it flags a rising transition
// against the value held at the previous clock edge; in level mode it raises
// either a drive-high request or a force-low request per the polarity bit.
// Outputs are combinational; the caller registers the merged result.
module pirq_line_cond (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic edge_mode_i,
    input  logic act_high_i,
    output logic pulse_o,
    output logic hi_req_o,
    output logic lo_force_o
);

    logic prev_q;

    // Hold the line value seen at the last clock edge for edge detection
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= line_i;
    end

    // Classify the line into one of the three request kinds
    always_comb begin
        pulse_o    = edge_mode_i  & line_i & ~prev_q;
        hi_req_o   = ~edge_mode_i & line_i & act_high_i;
        lo_force_o = ~edge_mode_i & line_i & ~act_high_i;
    end

endmodule

// File: rtl/pirq_router.sv
// pirq_router
// Top of the slot-based PCI interrupt router: swizzles slot pins onto the
// internal line space, conditions every line by its mode and polarity bits,
// and merges the results into one registered CPU request. A force-low level
// request dominates all pulses and drive-high requests.
module pirq_router #(
    parameter int FIRST_SLOT    = pirq_pkg::FIRST_SLOT,
    parameter int NUM_SLOTS     = pirq_pkg::NUM_SLOTS,
    parameter int PINS_PER_SLOT = pirq_pkg::PINS_PER_SLOT,
    parameter int NUM_LINES     = pirq_pkg::NUM_LINES,
    localparam int PIN_W        = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [PIN_W-1:0]     slot_pins_i,
    input  logic [NUM_LINES-1:0] edge_cfg_i,
    input  logic [NUM_LINES-1:0] pol_cfg_i,
    output logic [NUM_LINES-1:0] line_vec_o,
    output logic                 cpu_irq_o
);

    logic [NUM_LINES-1:0] pulse_v;
    logic [NUM_LINES-1:0] hi_v;
    logic [NUM_LINES-1:0] lo_v;
    logic                 irq_d;
    logic                 irq_q;

    pirq_swizzle #(
        .FIRST_SLOT    (FIRST_SLOT),
        .NUM_SLOTS     (NUM_SLOTS),
        .PINS_PER_SLOT (PINS_PER_SLOT),
        .NUM_LINES     (NUM_LINES)
    ) u_swizzle (
        .pins_i  (slot_pins_i),
        .lines_o (line_vec_o)
    );

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_cond
        pirq_line_cond u_cond (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .line_i      (line_vec_o[k]),
            .edge_mode_i (edge_cfg_i[k]),
            .act_high_i  (pol_cfg_i[k]),
            .pulse_o     (pulse_v[k]),
            .hi_req_o    (hi_v[k]),
            .lo_force_o  (lo_v[k])
        );
    end

    // Merge: any pulse or drive-high request, unless a line forces low
    always_comb begin
        irq_d = (|pulse_v | |hi_v) & ~(|lo_v);
    end

    // Register the merged request toward the CPU
    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign cpu_irq_o = irq_q;

endmodule

// File: rtl/pirq_router_chk.sv
// pirq_router_chk
// Property checker for pirq_router, attached by bind. Observes only the
// top-level ports; assumes the default slot swizzle for the unused-line check.
module pirq_router_chk #(
    parameter int NUM_LINES  = pirq_pkg::NUM_LINES,
    parameter int USED_LINES = pirq_pkg::USED_LINES
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_LINES-1:0] line_vec_i,
    input logic [NUM_LINES-1:0] edge_cfg_i,
    input logic [NUM_LINES-1:0] pol_cfg_i,
    input logic                 cpu_irq_i
);

    logic                 any_lo;
    logic                 any_hi;
    logic [NUM_LINES-1:0] unused_lines;

    always_comb begin
        any_lo       = |(line_vec_i & ~edge_cfg_i & ~pol_cfg_i);
        any_hi       = |(line_vec_i & ~edge_cfg_i & pol_cfg_i);
        unused_lines = line_vec_i >> USED_LINES;
    end

    p_unused_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unused_lines == '0);

    p_reset_clear_r10: assert property (@(posedge clk_i)
        !rst_ni |=> !cpu_irq_i);

    p_force_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_lo |=> !cpu_irq_i);

    p_level_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (any_hi && !any_lo) |=> cpu_irq_i);

    p_pulse_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !any_lo && |(line_vec_i & edge_cfg_i & ~$past(line_vec_i)))
        |=> cpu_irq_i);

    p_pulse_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !any_hi && ((line_vec_i & edge_cfg_i & ~$past(line_vec_i)) == '0))
        |=> !cpu_irq_i);

endmodule

bind pirq_router pirq_router_chk #(
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_vec_i (line_vec_o),
    .edge_cfg_i (edge_cfg_i),
    .pol_cfg_i  (pol_cfg_i),
    .cpu_irq_i  (cpu_irq_o)
);

// File: tb/pirq_router_test.sv
// pirq_router_test
// Self-checking bench: a swizzle vector table walked by one loop, then
// directed tests of pulse, level, override and reset behaviour.
module pirq_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [31:0] edge_cfg = '0;
    logic [31:0] pol_cfg = '0;
    logic [31:0] line_vec;
    logic        cpu_irq;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pirq_router uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .slot_pins_i (pins),
        .edge_cfg_i  (edge_cfg),
        .pol_cfg_i   (pol_cfg),
        .line_vec_o  (line_vec),
        .cpu_irq_o   (cpu_irq)
    );

    // {pins, expected line vector}
    localparam logic [63:0] MAP_VEC [0:11] = '{
        {32'h0000_0001, 32'h0000_0001},   // slot5 pin0 -> line0
        {32'h0000_0008, 32'h0000_0008},   // slot5 pin3 -> line3
        {32'h0000_0040, 32'h0000_0010},   // slot6 pin2 -> line4
        {32'h0000_0100, 32'h0000_0020},   // slot7 pin0 -> line5
        {32'h0000_0F00, 32'h0000_0020},   // slot7 all  -> line5
        {32'h0000_1000, 32'h0000_0040},   // slot8 pin0 -> line6
        {32'h0001_2000, 32'h0000_0080},   // slot8 pin1 + slot9 pin0 -> line7
        {32'h8000_0000, 32'h0000_2000},   // slot12 pin3 -> line13
        {32'h0040_0000, 32'h0000_0400},   // slot10 pin2 -> line10
        {32'h0200_0000, 32'h0000_0400},   // slot11 pin1 -> line10
        {32'hFFFF_FFFF, 32'h0000_3FFF},   // all pins, lines 14..31 stay 0
        {32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock edge and sample shortly after it
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Change inputs away from the active edge
    task automatic drive(input logic [31:0] p, input logic [31:0] e, input logic [31:0] q);
        @(negedge clk);
        pins = p;
        edge_cfg = e;
        pol_cfg = q;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) step();
        check("R10 reset output", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Swizzle table: R1 R2 R3 R4 R5 (sampled combinationally)
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            pins = MAP_VEC[i][63:32];
            #1;
            check("R1 R2 R3 R4 R5 swizzle", line_vec, MAP_VEC[i][31:0]);
        end

        // Pulse mode on line0 (slot5 pin0)
        drive(32'h0, 32'h1, 32'h0);
        step(); step();
        check("R6 idle no pulse", {31'b0, cpu_irq}, 32'h0);
        drive(32'h1, 32'h1, 32'h0);
        step();
        check("R6 rise pulse", {31'b0, cpu_irq}, 32'h1);
        step();
        check("R6 pulse one cycle", {31'b0, cpu_irq}, 32'h0);
        step();
        check("R6 held line no repeat", {31'b0, cpu_irq}, 32'h0);
        drive(32'h0, 32'h1, 32'h0);
        step();
        check("R9 fall no pulse", {31'b0, cpu_irq}, 32'h0);
        drive(32'h1, 32'h1, 32'h0);
        step();
        check("R6 second rise pulse", {31'b0, cpu_irq}, 32'h1);
        drive(32'h0, 32'h0, 32'h0);
        step();

        // Active-high level on line4 (slot6 pin1, bit5)
        drive(32'h20, 32'h0, 32'h10);
        step();
        check("R7 level high", {31'b0, cpu_irq}, 32'h1);
        step(); step();
        check("R7 level held", {31'b0, cpu_irq}, 32'h1);

        // Force-low from line5 (slot7 pin0, bit8) overrides line4
        drive(32'h120, 32'h0, 32'h10);
        step();
        check("R8 force low over level", {31'b0, cpu_irq}, 32'h0);
        drive(32'h20, 32'h0, 32'h10);
        step();
        check("R8 release restores level", {31'b0, cpu_irq}, 32'h1);
        drive(32'h0, 32'h0, 32'h10);
        step();
        check("R9 level drop", {31'b0, cpu_irq}, 32'h0);

        // Force-low overrides a fresh pulse on line0
        drive(32'h101, 32'h1, 32'h0);
        step();
        check("R8 force low over pulse", {31'b0, cpu_irq}, 32'h0);
        drive(32'h0, 32'h1, 32'h0);
        step();

        // Shared expansion line7 in level mode via slot9 pin0 (bit16)
        drive(32'h1_0000, 32'h0, 32'h80);
        step();
        check("R3 shared line level", {31'b0, cpu_irq}, 32'h1);

        // Reset during an active level request
        @(negedge clk);
        rst_n = 1'b0;
        step();
        check("R10 reset clears output", {31'b0, cpu_irq}, 32'h0);
        drive(32'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule